// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing

This block is the control and status register file for up to two DMA channels. It sits behind a plain 32-bit register port. For each channel it stores a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. It tracks the run/stop, soft-reset, halted and idle state, and drives one interrupt line per channel.

Completion interrupts are coalesced in two ways. A packet counter raises an interrupt after a programmable number of completed packets. A delay timer restarts on every completion and raises a second interrupt once it runs out. The timer ticks on a prescaled enable input. The live counter and timer values can be read back in the upper bytes of the status word.

The descriptor engine is outside this block. It reports to the block through three per-channel pulse inputs: packet completed, descriptor already complete (halt), and tail reached (idle). The block gives it the two pointers and a one-cycle start strobe whenever software writes the tail pointer.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, each channel's control word reads 0x0001_0002, its status word reads 0x0001_0001, and its interrupt line is low.
- R2: Address decode works as follows:
  - The channel is ((addr / 0x30) & 1).
  - Within a channel, the offsets are control 0x00, status 0x04, current pointer 0x08 and tail pointer 0x10.
  - Other offsets read 0, and writes to them are ignored.
  - Read data appears on rdata_o in the cycle after rd_en_i and holds until the next read.
- R3: The control word has these fields:
  - Bit 0 is run.
  - Bit 1 is tail-pointer mode and always reads 1.
  - Bit 2 is soft reset and always reads 0.
  - Bits 14:12 are interrupt enables: bit 12 for the count interrupt, bit 13 for the delay interrupt.
  - Bits 23:16 are the count threshold.
  - Bits 31:24 are the delay value.
- R4: A control write with run = 1 and soft reset = 0 clears status bit 0 (halted) and bit 1 (idle). A halt pulse sets halted, and a tail-reached pulse sets idle.
- R5: A control write with bit 2 set returns that channel's control word, status word, counter and timer to their reset values.
- R6: Every control write loads the packet counter from the written threshold field.
- R7: Each completion pulse decrements the counter. When a completion finds the counter at 1, status bit 12 is set and the counter reloads from the threshold.
- R8: Delay timer behaviour:
  - A completion with a nonzero delay field restarts the timer from that value.
  - The timer decrements on each tick_i while it is nonzero.
  - When it steps from 1 to 0, status bit 13 is set and the counter reloads.
  - With a delay field of 0, the timer does not start.
- R9: Writing 1 to status bits 14:12 clears them. All other status bits ignore writes.
- R10: irq_o for a channel is the OR over bits 14:12 of (status AND control).
- R11: A status read returns the timer count in bits 31:24, the counter in bits 23:16, the pending interrupts in bits 14:12, idle in bit 1 and halted in bit 0.
- R12: A tail-pointer write stores the pointer, clears idle, and pulses that channel's tail_start_o for exactly the next cycle.
- R13: A current-pointer write updates the corresponding cur_desc_o slice, which otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pkt_done_i | input | NUM_CH | Packet completed pulse per channel |
| desc_halt_i | input | NUM_CH | Descriptor already complete, sets halted |
| ring_idle_i | input | NUM_CH | Tail descriptor reached, sets idle |
| tick_i | input | 1 | Prescaled delay-timer enable |
| irq_o | output | NUM_CH | Interrupt per channel |
| cur_desc_o | output | 32*NUM_CH | Current-descriptor pointers |
| tail_desc_o | output | 32*NUM_CH | Tail-descriptor pointers |
| tail_start_o | output | NUM_CH | One-cycle start strobe after a tail write |

## Verification
The result of a write or of an engine pulse lands at the clock edge that samples it. The bench therefore checks irq_o and tail_start_o at the falling edge that immediately follows the stimulus. Read data is registered, so a read issued before an edge is compared one cycle later. The driver queues the expected word together with the read, and the monitor compares it at that falling edge. Timer and counter values are checked after an exact number of tick or completion pulses, each one cycle long.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 8;
  localparam int TMR_W   = 8;
  localparam int CH_SPAN = 48;
  localparam int CB_RUN  = 0;
  localparam int CB_TAIL = 1;
  localparam int CB_SRST = 2;
  localparam int IRQ_LO  = 12;
  localparam int IRQ_N   = 3;
  localparam int THR_LO  = 16;
  localparam int DLY_LO  = 24;
  localparam logic [REG_W-1:0] CTRL_RST = 32'h0001_0000;
  localparam logic [CNT_W-1:0] CNT_RST  = 8'd1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CUR, SEL_TAIL
  } reg_sel_e;
endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ch_o,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(CH_SPAN);

  logic [ADDR_W-1:0] blk;
  logic [ADDR_W-1:0] off;

  always_comb begin
    blk  = addr_i / SPAN;
    off  = addr_i % SPAN;
    ch_o = blk[0];
    unique case (off[5:0])
      6'h00:   sel_o = SEL_CTRL;
      6'h04:   sel_o = SEL_STAT;
      6'h08:   sel_o = SEL_CUR;
      6'h10:   sel_o = SEL_TAIL;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dma_coalesce.sv
module dma_coalesce
  import dma_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [TMR_W-1:0] dly_i,
  input  logic             done_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic             cnt_hit_o,
  output logic             tmr_hit_o
);
  logic restart, expire;

  assign restart   = done_i && (dly_i != '0);
  assign expire    = tick_i && (tmr_o == TMR_W'(1)) && !restart;
  assign cnt_hit_o = done_i && (cnt_o == CNT_W'(1)) && !reload_i;
  assign tmr_hit_o = expire && !soft_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= CNT_RST;
      tmr_o <= '0;
    end else begin
      if (reload_i)                    cnt_o <= reload_val_i;
      else if (done_i)                 cnt_o <= (cnt_o == CNT_W'(1)) ? thr_i : cnt_o - CNT_W'(1);
      else if (expire)                 cnt_o <= thr_i;

      if (soft_clr_i)                  tmr_o <= '0;
      else if (restart)                tmr_o <= dly_i;
      else if (tick_i && tmr_o != '0)  tmr_o <= tmr_o - TMR_W'(1);
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             done_i,
  input  logic             halt_i,
  input  logic             idle_i,
  input  logic             tick_i,
  output logic [REG_W-1:0] rword_o,
  output logic             irq_o,
  output logic [REG_W-1:0] cur_o,
  output logic [REG_W-1:0] tail_o,
  output logic             start_o
);
  logic [REG_W-1:0] ctrl_q;
  logic             halt_q, idle_q;
  logic [IRQ_N-1:0] pend_q, pend_set, pend_clr;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             cnt_hit, tmr_hit;
  logic             wr_ctrl, wr_stat, srst;

  assign wr_ctrl  = wr_i && (sel_i == SEL_CTRL);
  assign wr_stat  = wr_i && (sel_i == SEL_STAT);
  assign srst     = wr_ctrl && wdata_i[CB_SRST];
  assign pend_set = {1'b0, tmr_hit, cnt_hit};
  assign pend_clr = wr_stat ? wdata_i[IRQ_LO +: IRQ_N] : '0;

  dma_coalesce u_coal (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_clr_i   (srst),
    .reload_i     (wr_ctrl),
    .reload_val_i (srst ? CNT_RST : wdata_i[THR_LO +: CNT_W]),
    .thr_i        (ctrl_q[THR_LO +: CNT_W]),
    .dly_i        (ctrl_q[DLY_LO +: TMR_W]),
    .done_i       (done_i),
    .tick_i       (tick_i),
    .cnt_o        (cnt),
    .tmr_o        (tmr),
    .cnt_hit_o    (cnt_hit),
    .tmr_hit_o    (tmr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      halt_q  <= 1'b1;
      idle_q  <= 1'b0;
      pend_q  <= '0;
      cur_o   <= '0;
      tail_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (halt_i) halt_q <= 1'b1;
      if (idle_i) idle_q <= 1'b1;
      pend_q <= (pend_q | pend_set) & ~pend_clr;
      if (wr_ctrl) begin
        if (srst) begin
          ctrl_q <= CTRL_RST;
          halt_q <= 1'b1;
          idle_q <= 1'b0;
          pend_q <= '0;
        end else begin
          ctrl_q <= wdata_i & ~(REG_W'(1) << CB_TAIL) & ~(REG_W'(1) << CB_SRST);
          if (wdata_i[CB_RUN]) begin
            halt_q <= 1'b0;
            idle_q <= 1'b0;
          end
        end
      end
      if (wr_i && sel_i == SEL_CUR) cur_o <= wdata_i;
      if (wr_i && sel_i == SEL_TAIL) begin
        tail_o  <= wdata_i;
        idle_q  <= 1'b0;
        start_o <= 1'b1;
      end
    end
  end

  assign irq_o = |(pend_q & ctrl_q[IRQ_LO +: IRQ_N]);

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rword_o = ctrl_q | (REG_W'(1) << CB_TAIL);
      SEL_STAT: rword_o = {tmr, cnt, 1'b0, pend_q, 10'b0, idle_q, halt_q};
      SEL_CUR:  rword_o = cur_o;
      SEL_TAIL: rword_o = tail_o;
      default:  rword_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_CH-1:0]       pkt_done_i,
  input  logic [NUM_CH-1:0]       desc_halt_i,
  input  logic [NUM_CH-1:0]       ring_idle_i,
  input  logic                    tick_i,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [32*NUM_CH-1:0]    cur_desc_o,
  output logic [32*NUM_CH-1:0]    tail_desc_o,
  output logic [NUM_CH-1:0]       tail_start_o
);
  logic             dec_ch;
  reg_sel_e         dec_sel;
  logic [REG_W-1:0] rword [NUM_CH];
  logic [REG_W-1:0] rdata_d;

  dma_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .ch_o   (dec_ch),
    .sel_o  (dec_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (int'(dec_ch) == c)),
      .sel_i   (dec_sel),
      .wdata_i (wdata_i),
      .done_i  (pkt_done_i[c]),
      .halt_i  (desc_halt_i[c]),
      .idle_i  (ring_idle_i[c]),
      .tick_i  (tick_i),
      .rword_o (rword[c]),
      .irq_o   (irq_o[c]),
      .cur_o   (cur_desc_o[32*c +: 32]),
      .tail_o  (tail_desc_o[32*c +: 32]),
      .start_o (tail_start_o[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(dec_ch) == c) rdata_d = rword[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_CH-1:0]    pkt_done_i,
  input logic                 tick_i,
  input logic [NUM_CH-1:0]    irq_o,
  input logic [32*NUM_CH-1:0] cur_desc_o,
  input logic [NUM_CH-1:0]    tail_start_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[g]) |-> $past(wr_en_i)); // R10
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> $past(pkt_done_i[g] || tick_i || wr_en_i)); // R7
  end
  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tail_start_o)); // R12
  AST_START_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tail_start_o) |-> $past(wr_en_i)); // R12
  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cur_desc_o)); // R13
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R2
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .rdata_o      (rdata_o),
  .pkt_done_i   (pkt_done_i),
  .tick_i       (tick_i),
  .irq_o        (irq_o),
  .cur_desc_o   (cur_desc_o),
  .tail_start_o (tail_start_o)
);

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
  localparam int TCLK = 10;
  localparam int NCH  = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]        addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NCH-1:0]    pkt_done_i = '0, desc_halt_i = '0, ring_idle_i = '0;
  logic              tick_i = 1'b0;
  logic [NCH-1:0]    irq_o, tail_start_o;
  logic [32*NCH-1:0] cur_desc_o, tail_desc_o;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done_flag = 0;

  always #(TCLK/2) clk_i = ~clk_i;

  dma_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) u_dma_irq_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic done(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); pkt_done_i[ch] = 1'b1;
      @(negedge clk_i); pkt_done_i[ch] = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  // monitor: compares queued read results one cycle after the read strobe
  initial begin
    logic pend;
    forever begin
      @(posedge clk_i); pend = rd_en_i;
      @(negedge clk_i);
      if (pend) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rdata_o === e, t, 64'(rdata_o), 64'(e));
      end
    end
  end

  initial begin
    #(TCLK * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8'h00, 32'h0001_0002, "R1 ctrl reset");
    rd(8'h04, 32'h0001_0001, "R1 R11 status reset");
    chk(irq_o === 2'b00, "R1 irq reset", 64'(irq_o), 0);
    rd(8'h0C, 32'h0, "R2 unmapped offset");

    wr(8'h00, 32'h0003_1001);
    rd(8'h00, 32'h0003_1003, "R3 tail mode reads 1");
    rd(8'h04, 32'h0003_0000, "R4 run clears halted");
    done(0, 2);
    rd(8'h04, 32'h0001_0000, "R7 counter decrements");
    chk(irq_o[0] === 1'b0, "R7 no irq before threshold", 64'(irq_o), 0);
    done(0, 1);
    chk(irq_o[0] === 1'b1, "R7 R10 count irq", 64'(irq_o), 1);
    rd(8'h04, 32'h0003_1000, "R7 reload after hit");
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, 32'h0003_1000, "R9 non-irq bits ignore writes");
    wr(8'h04, 32'h0000_1000);
    chk(irq_o[0] === 1'b0, "R9 w1c drops irq", 64'(irq_o), 0);
    rd(8'h04, 32'h0003_0000, "R9 w1c clears bit");
    done(0, 1);
    wr(8'h00, 32'h0003_1001);
    rd(8'h04, 32'h0003_0000, "R6 control write reloads");

    wr(8'h00, 32'h0504_2001);
    rd(8'h04, 32'h0004_0000, "R6 reload new threshold");
    done(0, 1);
    rd(8'h04, 32'h0503_0000, "R8 timer start");
    ticks(4);
    rd(8'h04, 32'h0103_0000, "R8 timer counts down");
    ticks(1);
    chk(irq_o[0] === 1'b1, "R8 delay irq", 64'(irq_o), 1);
    rd(8'h04, 32'h0004_2000, "R8 expiry reloads counter");
    wr(8'h04, 32'h0000_2000);
    done(0, 1);
    ticks(3);
    done(0, 1);
    rd(8'h04, 32'h0502_0000, "R8 restart on completion");
    ticks(5);
    rd(8'h04, 32'h0004_2000, "R8 expiry after restart");
    wr(8'h04, 32'h0000_2000);
    wr(8'h00, 32'h0004_2001);
    done(0, 1);
    rd(8'h04, 32'h0003_0000, "R8 zero delay no timer");

    wr(8'h00, 32'h0001_0001);
    done(0, 1);
    chk(irq_o[0] === 1'b0, "R10 masked pending", 64'(irq_o), 0);
    rd(8'h04, 32'h0001_1000, "R10 pending while masked");
    wr(8'h00, 32'h0001_1001);
    chk(irq_o[0] === 1'b1, "R10 enable exposes pending", 64'(irq_o), 1);
    @(negedge clk_i); desc_halt_i[0] = 1'b1;
    @(negedge clk_i); desc_halt_i[0] = 1'b0;
    rd(8'h04, 32'h0001_1001, "R4 halt input");

    wr(8'h00, 32'h0000_0004);
    chk(irq_o[0] === 1'b0, "R5 soft reset irq", 64'(irq_o), 0);
    rd(8'h00, 32'h0001_0002, "R5 ctrl after soft reset");
    rd(8'h04, 32'h0001_0001, "R5 status after soft reset");

    wr(8'h00, 32'h0001_0001);
    @(negedge clk_i); ring_idle_i[0] = 1'b1;
    @(negedge clk_i); ring_idle_i[0] = 1'b0;
    rd(8'h04, 32'h0001_0002, "R4 idle input");
    wr(8'h10, 32'h0000_0400);
    chk(tail_start_o === 2'b01, "R12 start pulse", 64'(tail_start_o), 1);
    chk(tail_desc_o[31:0] === 32'h400, "R12 tail out", 64'(tail_desc_o[31:0]), 64'h400);
    @(negedge clk_i);
    chk(tail_start_o === 2'b00, "R12 pulse one cycle", 64'(tail_start_o), 0);
    rd(8'h04, 32'h0001_0000, "R12 tail clears idle");
    rd(8'h10, 32'h0000_0400, "R12 tail readback");

    wr(8'h08, 32'h0000_1234);
    wr(8'h38, 32'hABCD_0000);
    chk(cur_desc_o === 64'hABCD_0000_0000_1234, "R13 R2 cur pointers", cur_desc_o, 64'hABCD_0000_0000_1234);
    rd(8'h98, 32'hABCD_0000, "R2 alias to channel 1");
    rd(8'h30, 32'h0001_0002, "R2 channel 1 ctrl");

    wr(8'h30, 32'h0002_1001);
    done(1, 2);
    chk(irq_o === 2'b10, "R7 channel 1 independent", 64'(irq_o), 64'h2);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all reads returned", 64'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule